// File: doc/BRIEF.md
# Card-side flash pair controller

This block is the control logic that sits inside a removable memory card between a 16-bit card host bus and an array of byte-wide flash devices arranged in pairs (one low-byte device, one high-byte device per pair). On every clock it samples the host strobes, the two active-low byte enables and the address. From these it works out which pair is addressed, which byte device or devices take part, and how the bytes must be routed between the host lanes and the devices. An 8-bit host can then reach both bytes of a pair through the low lanes alone.

The block also separates attribute-plane accesses from flash accesses. It blocks flash writes while the write-protect switch is on, and it merges the ready lines of all devices into one card ready flag. Every output is registered, so a decision made on the inputs sampled at clock edge N appears on the outputs after edge N. Pad tri-stating is left to the pad ring, which follows the two lane drive flags.

Top module: `pcc_flash_ctl`

## Requirements
- R1: With both byte enables high, the outputs after the next edge show no pair select, no device read or write strobe, no attribute strobe and neither lane drive flag.
- R2: With both byte enables low (word mode), bit 0 of the address is ignored. Both byte devices are strobed, read data is {high device byte, low device byte}, and `arr_hi_d` takes `host_wdata[15:8]`.
- R3: With only the even enable low and address bit 0 = 0, only the low byte device is strobed and its byte is returned on `host_rdata[7:0]`.
- R4: With only the even enable low and address bit 0 = 1, only the high byte device is strobed. Its byte is steered onto `host_rdata[7:0]`, `host_wdata[7:0]` is steered onto `arr_hi_d`, and only the low lane is driven.
- R5: With only the odd enable low, only the high byte device is strobed, its byte appears on `host_rdata[15:8]` and only the high lane is driven.
- R6: Address bits 25..22 form the pair index. A populated index raises exactly the matching bit of `pair_sel`. `dev_addr` carries address bits 21..1.
- R7: A pair index at or above `NUM_PAIRS` selects no pair and strobes no device. Read data on the lanes being driven is all ones (0xFF per lane).
- R8: With `host_attr_n` low, no pair is selected and no flash strobe fires. A read returns `attr_q` on the low lane and 0xFF on the high lane. A write raises `attr_wr` whatever the write-protect switch says.
- R9: While `wp_on` is high, no flash write strobe (`lo_wr`, `hi_wr`) is raised.
- R10: `card_ready` is high after an edge only if every bit of `dev_ready` was high at that edge. One busy device drives it low.
- R11: A high `rst` at an edge clears every registered output, including `card_ready`, at that edge.
- R12: `wait_n` is always high.
- R13: A lane drive flag is raised only for a read: output enable low, write enable high and at least one byte enable low. Undriven lanes of `host_rdata` read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high card reset |
| host_addr | input | 26 | Host byte address |
| host_ce_even_n | input | 1 | Even byte enable, active low |
| host_ce_odd_n | input | 1 | Odd byte enable, active low |
| host_oe_n | input | 1 | Output enable, active low |
| host_we_n | input | 1 | Write enable, active low |
| host_attr_n | input | 1 | Attribute plane select, active low |
| wp_on | input | 1 | Write-protect switch, high locks flash writes |
| host_wdata | input | 16 | Host write data |
| arr_lo_q | input | 8 | Read byte from the low device of the addressed pair |
| arr_hi_q | input | 8 | Read byte from the high device of the addressed pair |
| attr_q | input | 8 | Read byte from the attribute store |
| dev_ready | input | 2*NUM_PAIRS | Per-device ready, high = ready |
| pair_sel | output | NUM_PAIRS | One-hot pair select |
| dev_addr | output | 21 | Word address inside a pair |
| lo_rd | output | 1 | Low byte device read strobe |
| hi_rd | output | 1 | High byte device read strobe |
| lo_wr | output | 1 | Low byte device write strobe |
| hi_wr | output | 1 | High byte device write strobe |
| arr_lo_d | output | 8 | Write byte to the low device |
| arr_hi_d | output | 8 | Write byte to the high device |
| host_rdata | output | 16 | Read data toward the host lanes |
| drv_lo | output | 1 | Drive host lanes 7..0 |
| drv_hi | output | 1 | Drive host lanes 15..8 |
| attr_rd | output | 1 | Attribute store read strobe |
| attr_wr | output | 1 | Attribute store write strobe |
| card_ready | output | 1 | Merged ready, low when any device is busy |
| wait_n | output | 1 | Wait request, held high |

## Verification
The embedded properties watch the invariants every cycle. They check that at most one pair is selected, that attribute strobes never coexist with a pair select, and that the write lock, the idle state, an unpopulated index and a non-read cycle each suppress their outputs one edge later. They also check that a busy device pulls ready low and that reset clears everything. What only the scenarios show is the data itself: the lane swap for an 8-bit host on odd addresses, the word and odd-only routing, the all-ones fill for empty pair slots and the attribute byte placement. The bench compares every registered output against a model written from the requirements, using random traffic and directed boundary cases such as pair 9, index 10 and index 15.

// File: rtl/pcc_pkg.sv
`timescale 1ns/1ps
package pcc_pkg;

  // Byte-lane routing chosen from the two enables and address bit 0.
  typedef enum logic [2:0] {
    LANE_IDLE     = 3'd0,
    LANE_WORD     = 3'd1,
    LANE_EVEN     = 3'd2,
    LANE_ODD_SWAP = 3'd3,
    LANE_ODD_HIGH = 3'd4
  } lane_e;

  // Per-cycle lane capabilities derived from the routing mode.
  typedef struct packed {
    logic active;  // at least one enable low
    logic lo_dev;  // low byte device takes part
    logic hi_dev;  // high byte device takes part
    logic use_lo;  // host lanes 7..0 carry data
    logic use_hi;  // host lanes 15..8 carry data
    logic swap;    // high device byte travels on the low lanes
  } lane_ctl_t;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/pcc_lane_decode.sv
`timescale 1ns/1ps
module pcc_lane_decode
  import pcc_pkg::*;
(
  input  logic      ce_even_n,
  input  logic      ce_odd_n,
  input  logic      a0,
  output lane_ctl_t ctl
);

  lane_e mode;

  always_comb begin
    unique case ({ce_even_n, ce_odd_n})
      2'b11:   mode = LANE_IDLE;
      2'b00:   mode = LANE_WORD;
      2'b01:   mode = a0 ? LANE_ODD_SWAP : LANE_EVEN;
      default: mode = LANE_ODD_HIGH;
    endcase
  end

  always_comb begin
    ctl = '0;
    unique case (mode)
      LANE_WORD: begin
        ctl.active = 1'b1;
        ctl.lo_dev = 1'b1;
        ctl.hi_dev = 1'b1;
        ctl.use_lo = 1'b1;
        ctl.use_hi = 1'b1;
      end
      LANE_EVEN: begin
        ctl.active = 1'b1;
        ctl.lo_dev = 1'b1;
        ctl.use_lo = 1'b1;
      end
      LANE_ODD_SWAP: begin
        ctl.active = 1'b1;
        ctl.hi_dev = 1'b1;
        ctl.use_lo = 1'b1;
        ctl.swap   = 1'b1;
      end
      LANE_ODD_HIGH: begin
        ctl.active = 1'b1;
        ctl.hi_dev = 1'b1;
        ctl.use_hi = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/pcc_pair_decode.sv
`timescale 1ns/1ps
module pcc_pair_decode #(
  parameter int unsigned NUM_PAIRS = 10,
  parameter int unsigned IDX_W     = 4
) (
  input  logic [IDX_W-1:0]     idx,
  input  logic                 enable,
  output logic                 populated,
  output logic [NUM_PAIRS-1:0] sel
);

  localparam int unsigned CMP_W = IDX_W + 1;

  assign populated = ({1'b0, idx} < CMP_W'(NUM_PAIRS));

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign sel[p] = enable && (idx == IDX_W'(p));
  end

endmodule

// File: rtl/pcc_read_steer.sv
`timescale 1ns/1ps
module pcc_read_steer
  import pcc_pkg::*;
(
  input  lane_ctl_t         ctl,
  input  logic              rd,
  input  logic              attr,
  input  logic              populated,
  input  logic [BYTE_W-1:0] arr_lo_q,
  input  logic [BYTE_W-1:0] arr_hi_q,
  input  logic [BYTE_W-1:0] attr_q,
  output logic [2*BYTE_W-1:0] rdata,
  output logic              drv_lo,
  output logic              drv_hi
);

  localparam logic [BYTE_W-1:0] FILL = '1;

  logic [BYTE_W-1:0] src_lo;
  logic [BYTE_W-1:0] src_hi;

  always_comb begin
    if (attr) begin
      src_lo = attr_q;
      src_hi = FILL;
    end else if (!populated) begin
      src_lo = FILL;
      src_hi = FILL;
    end else begin
      src_lo = ctl.swap ? arr_hi_q : arr_lo_q;
      src_hi = arr_hi_q;
    end
  end

  assign drv_lo = rd && ctl.active && ctl.use_lo;
  assign drv_hi = rd && ctl.active && ctl.use_hi;
  assign rdata  = {drv_hi ? src_hi : '0, drv_lo ? src_lo : '0};

endmodule

// File: rtl/pcc_ready_merge.sv
`timescale 1ns/1ps
module pcc_ready_merge #(
  parameter int unsigned NUM_DEV = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_DEV-1:0] dev_ready,
  output logic               card_ready
);

  always_ff @(posedge clk) begin
    if (rst) card_ready <= 1'b0;
    else     card_ready <= &dev_ready;
  end

endmodule

// File: rtl/pcc_flash_ctl.sv
`timescale 1ns/1ps
module pcc_flash_ctl
  import pcc_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 10,
  parameter int unsigned ADDR_W    = 26,
  parameter int unsigned IDX_LSB   = 22
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      host_addr,
  input  logic                   host_ce_even_n,
  input  logic                   host_ce_odd_n,
  input  logic                   host_oe_n,
  input  logic                   host_we_n,
  input  logic                   host_attr_n,
  input  logic                   wp_on,
  input  logic [15:0]            host_wdata,
  input  logic [7:0]             arr_lo_q,
  input  logic [7:0]             arr_hi_q,
  input  logic [7:0]             attr_q,
  input  logic [2*NUM_PAIRS-1:0] dev_ready,
  output logic [NUM_PAIRS-1:0]   pair_sel,
  output logic [IDX_LSB-2:0]     dev_addr,
  output logic                   lo_rd,
  output logic                   hi_rd,
  output logic                   lo_wr,
  output logic                   hi_wr,
  output logic [7:0]             arr_lo_d,
  output logic [7:0]             arr_hi_d,
  output logic [15:0]            host_rdata,
  output logic                   drv_lo,
  output logic                   drv_hi,
  output logic                   attr_rd,
  output logic                   attr_wr,
  output logic                   card_ready,
  output logic                   wait_n
);

  localparam int unsigned IDX_W   = ADDR_W - IDX_LSB;
  localparam int unsigned WADDR_W = IDX_LSB - 1;
  localparam int unsigned NUM_DEV = 2 * NUM_PAIRS;

  // ---------------- decode ----------------
  lane_ctl_t ctl;
  logic      rd_cyc, wr_cyc, attr_cyc, flash_cyc, populated;
  logic [NUM_PAIRS-1:0] sel_nx;

  pcc_lane_decode u_lane (
    .ce_even_n (host_ce_even_n),
    .ce_odd_n  (host_ce_odd_n),
    .a0        (host_addr[0]),
    .ctl       (ctl)
  );

  assign rd_cyc    = !host_oe_n && host_we_n;
  assign wr_cyc    = !host_we_n;
  assign attr_cyc  = !host_attr_n && ctl.active;
  assign flash_cyc = host_attr_n && ctl.active;

  pcc_pair_decode #(.NUM_PAIRS(NUM_PAIRS), .IDX_W(IDX_W)) u_pair (
    .idx       (host_addr[ADDR_W-1:IDX_LSB]),
    .enable    (flash_cyc),
    .populated (populated),
    .sel       (sel_nx)
  );

  logic [15:0] rdata_nx;
  logic        drv_lo_nx, drv_hi_nx;

  pcc_read_steer u_steer (
    .ctl       (ctl),
    .rd        (rd_cyc),
    .attr      (!host_attr_n),
    .populated (populated),
    .arr_lo_q  (arr_lo_q),
    .arr_hi_q  (arr_hi_q),
    .attr_q    (attr_q),
    .rdata     (rdata_nx),
    .drv_lo    (drv_lo_nx),
    .drv_hi    (drv_hi_nx)
  );

  logic dev_go, wr_ok;
  assign dev_go = flash_cyc && populated;
  assign wr_ok  = dev_go && wr_cyc && !wp_on;

  // ---------------- output registers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      pair_sel   <= '0;
      dev_addr   <= '0;
      lo_rd      <= 1'b0;
      hi_rd      <= 1'b0;
      lo_wr      <= 1'b0;
      hi_wr      <= 1'b0;
      arr_lo_d   <= '0;
      arr_hi_d   <= '0;
      host_rdata <= '0;
      drv_lo     <= 1'b0;
      drv_hi     <= 1'b0;
      attr_rd    <= 1'b0;
      attr_wr    <= 1'b0;
    end else begin
      pair_sel   <= sel_nx;
      dev_addr   <= host_addr[IDX_LSB-1:1];
      lo_rd      <= dev_go && rd_cyc && ctl.lo_dev;
      hi_rd      <= dev_go && rd_cyc && ctl.hi_dev;
      lo_wr      <= wr_ok && ctl.lo_dev;
      hi_wr      <= wr_ok && ctl.hi_dev;
      arr_lo_d   <= host_wdata[7:0];
      arr_hi_d   <= ctl.swap ? host_wdata[7:0] : host_wdata[15:8];
      host_rdata <= rdata_nx;
      drv_lo     <= drv_lo_nx;
      drv_hi     <= drv_hi_nx;
      attr_rd    <= attr_cyc && rd_cyc;
      attr_wr    <= attr_cyc && wr_cyc;
    end
  end

  pcc_ready_merge #(.NUM_DEV(NUM_DEV)) u_rdy (
    .clk        (clk),
    .rst        (rst),
    .dev_ready  (dev_ready),
    .card_ready (card_ready)
  );

  assign wait_n = 1'b1;

  // ---------------- assertions ----------------
  a_r6_pair_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pair_sel));

  a_r8_attr_excl: assert property (@(posedge clk) disable iff (rst)
    (attr_rd || attr_wr) |-> (pair_sel == '0 && !lo_wr && !hi_wr && !lo_rd && !hi_rd));

  a_r9_wp_lockout: assert property (@(posedge clk) disable iff (rst)
    wp_on |=> (!lo_wr && !hi_wr));

  a_r1_idle: assert property (@(posedge clk) disable iff (rst)
    (host_ce_even_n && host_ce_odd_n) |=>
      (pair_sel == '0 && !lo_rd && !hi_rd && !lo_wr && !hi_wr &&
       !attr_rd && !attr_wr && !drv_lo && !drv_hi));

  a_r7_unpopulated: assert property (@(posedge clk) disable iff (rst)
    (host_addr[ADDR_W-1:IDX_LSB] >= IDX_W'(NUM_PAIRS)) |=>
      (pair_sel == '0 && !lo_rd && !hi_rd && !lo_wr && !hi_wr));

  a_r13_drive_read_only: assert property (@(posedge clk) disable iff (rst)
    (host_oe_n || !host_we_n) |=> (!drv_lo && !drv_hi));

  a_r10_busy: assert property (@(posedge clk) disable iff (rst)
    !(&dev_ready) |=> !card_ready);

  a_r11_reset_clear: assert property (@(posedge clk)
    rst |=> (pair_sel == '0 && !lo_rd && !hi_rd && !lo_wr && !hi_wr &&
             !drv_lo && !drv_hi && !attr_rd && !attr_wr && !card_ready &&
             host_rdata == '0));

endmodule

// File: tb/pcc_flash_ctl_bench.sv
`timescale 1ns/1ps
module pcc_flash_ctl_bench;

  localparam int NP = 10;
  localparam int VW = NP + 63;

  logic        clk = 1'b0;
  logic        rst;
  logic [25:0] host_addr;
  logic        ce_e_n, ce_o_n, oe_n, we_n, attr_n, wp;
  logic [15:0] wdata;
  logic [7:0]  lo_q, hi_q, a_q;
  logic [2*NP-1:0] rdy_in;

  logic [NP-1:0] pair_sel;
  logic [20:0]   dev_addr;
  logic lo_rd, hi_rd, lo_wr, hi_wr, drv_lo, drv_hi, attr_rd, attr_wr, card_ready, wait_n;
  logic [7:0]  arr_lo_d, arr_hi_d;
  logic [15:0] host_rdata;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pcc_flash_ctl u_pcc_flash_ctl (
    .clk(clk), .rst(rst), .host_addr(host_addr),
    .host_ce_even_n(ce_e_n), .host_ce_odd_n(ce_o_n),
    .host_oe_n(oe_n), .host_we_n(we_n), .host_attr_n(attr_n), .wp_on(wp),
    .host_wdata(wdata), .arr_lo_q(lo_q), .arr_hi_q(hi_q), .attr_q(a_q),
    .dev_ready(rdy_in), .pair_sel(pair_sel), .dev_addr(dev_addr),
    .lo_rd(lo_rd), .hi_rd(hi_rd), .lo_wr(lo_wr), .hi_wr(hi_wr),
    .arr_lo_d(arr_lo_d), .arr_hi_d(arr_hi_d), .host_rdata(host_rdata),
    .drv_lo(drv_lo), .drv_hi(drv_hi), .attr_rd(attr_rd), .attr_wr(attr_wr),
    .card_ready(card_ready), .wait_n(wait_n)
  );

  // Expected registered outputs for the inputs currently applied.
  function automatic logic [VW-1:0] model();
    logic idle, word, even, swp, high, rd, wr, pop, flash, attr, lo_act, hi_act, dl, dh;
    logic [3:0] idx;
    logic [7:0] s_lo, s_hi;
    logic [NP-1:0] sel;
    logic [15:0] rdat;
    if (rst) return {{(VW-1){1'b0}}, 1'b1};
    idle = ce_e_n && ce_o_n;
    word = !ce_e_n && !ce_o_n;
    even = !ce_e_n && ce_o_n && !host_addr[0];
    swp  = !ce_e_n && ce_o_n && host_addr[0];
    high = ce_e_n && !ce_o_n;
    rd = !oe_n && we_n;
    wr = !we_n;
    idx = host_addr[25:22];
    pop = idx < NP;
    flash = attr_n && pop && !idle;
    attr = !attr_n && !idle;
    lo_act = word || even;
    hi_act = word || swp || high;
    dl = rd && (word || even || swp);
    dh = rd && (word || high);
    sel = '0;
    if (flash) sel[idx] = 1'b1;
    if (!attr_n)    begin s_lo = a_q;   s_hi = 8'hFF; end
    else if (!pop)  begin s_lo = 8'hFF; s_hi = 8'hFF; end
    else            begin s_lo = swp ? hi_q : lo_q; s_hi = hi_q; end
    rdat = {dh ? s_hi : 8'h00, dl ? s_lo : 8'h00};
    return {sel, host_addr[21:1],
            flash && rd && lo_act, flash && rd && hi_act,
            flash && wr && !wp && lo_act, flash && wr && !wp && hi_act,
            wdata[7:0], swp ? wdata[7:0] : wdata[15:8], rdat,
            dl, dh, attr && rd, attr && wr, &rdy_in, 1'b1};
  endfunction

  function automatic logic [VW-1:0] actual();
    return {pair_sel, dev_addr, lo_rd, hi_rd, lo_wr, hi_wr, arr_lo_d, arr_hi_d,
            host_rdata, drv_lo, drv_hi, attr_rd, attr_wr, card_ready, wait_n};
  endfunction

  // Apply current inputs across one edge and compare just after it.
  task automatic run(input string tag);
    logic [VW-1:0] e, a;
    e = model();
    @(posedge clk);
    #1;
    a = actual();
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    rst = 1'b0; host_addr = '0; ce_e_n = 1'b1; ce_o_n = 1'b1;
    oe_n = 1'b1; we_n = 1'b1; attr_n = 1'b1; wp = 1'b0;
    wdata = 16'h0; lo_q = 8'h00; hi_q = 8'h00; a_q = 8'h00; rdy_in = '1;
  endtask

  task automatic access(input logic [3:0] idx, input logic [20:0] w, input logic a0,
                        input logic e_n, input logic o_n, input logic is_wr);
    host_addr = {idx, w, a0};
    ce_e_n = e_n; ce_o_n = o_n;
    oe_n = is_wr; we_n = !is_wr;
  endtask

  function automatic string rand_tag();
    if (rst) return "R11";
    if (ce_e_n && ce_o_n) return "R1";
    if (!attr_n) return "R8";
    if (host_addr[25:22] >= NP) return "R7";
    if (wp && !we_n) return "R9";
    if (!ce_e_n && !ce_o_n) return "R2";
    if (!ce_e_n && !host_addr[0]) return "R3";
    if (!ce_e_n) return "R4";
    return "R5";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    idle_inputs();
    rst = 1'b1;
    @(negedge clk);
    run("R11 reset state");
    rst = 1'b0;
    run("R1 idle after reset");
    run("R12 wait held high");

    lo_q = 8'h3C; hi_q = 8'hA5; wdata = 16'hBEEF;
    access(4'd2, 21'h0ABCD, 1'b1, 1'b0, 1'b0, 1'b0); run("R2 word read, a0 ignored");
    access(4'd2, 21'h0ABCD, 1'b0, 1'b0, 1'b0, 1'b1); run("R2 word write");
    access(4'd0, 21'h00010, 1'b0, 1'b0, 1'b1, 1'b0); run("R3 even byte read");
    access(4'd0, 21'h00010, 1'b1, 1'b0, 1'b1, 1'b0); run("R4 odd byte swapped read");
    access(4'd0, 21'h00010, 1'b1, 1'b0, 1'b1, 1'b1); run("R4 odd byte swapped write");
    access(4'd5, 21'h1FFFF, 1'b0, 1'b1, 1'b0, 1'b0); run("R5 odd-only read on high lanes");
    access(4'd9, 21'h1FFFFF, 1'b0, 1'b0, 1'b0, 1'b0); run("R6 last pair select");
    access(4'd10, 21'h00001, 1'b0, 1'b0, 1'b0, 1'b0); run("R7 first empty index reads ones");
    access(4'd15, 21'h00001, 1'b1, 1'b0, 1'b1, 1'b1); run("R7 empty index write ignored");
    wp = 1'b1;
    access(4'd1, 21'h00020, 1'b0, 1'b0, 1'b0, 1'b1); run("R9 word write locked");
    access(4'd1, 21'h00020, 1'b1, 1'b0, 1'b1, 1'b1); run("R9 swapped byte write locked");
    attr_n = 1'b0; a_q = 8'h18;
    access(4'd0, 21'h00001, 1'b0, 1'b0, 1'b1, 1'b1); run("R8 attribute write despite lock");
    wp = 1'b0;
    access(4'd3, 21'h00000, 1'b0, 1'b0, 1'b0, 1'b0); run("R8 attribute word read");
    attr_n = 1'b1;
    access(4'd3, 21'h00004, 1'b0, 1'b0, 1'b0, 1'b0); oe_n = 1'b0; we_n = 1'b0;
    run("R13 oe and we both low: no drive");
    oe_n = 1'b1; we_n = 1'b1; run("R13 no strobe: no drive");
    rdy_in = '1; rdy_in[13] = 1'b0; run("R10 one device busy");
    rdy_in = '1; run("R10 all ready");
    rst = 1'b1; access(4'd4, 21'h00100, 1'b0, 1'b0, 1'b0, 1'b1); run("R11 reset during write");
    rst = 1'b0;

    for (int i = 0; i < 600; i++) begin
      host_addr = {$urandom} [25:0];
      ce_e_n = ($urandom % 4) == 0;
      ce_o_n = ($urandom % 2) == 0;
      oe_n   = ($urandom % 2) == 0;
      we_n   = ($urandom % 3) != 0;
      attr_n = ($urandom % 5) != 0;
      wp     = ($urandom % 4) == 0;
      rst    = ($urandom % 50) == 0;
      wdata  = {$urandom} [15:0];
      lo_q   = {$urandom} [7:0];
      hi_q   = {$urandom} [7:0];
      a_q    = {$urandom} [7:0];
      rdy_in = '1;
      if (($urandom % 4) == 0) rdy_in[$urandom % (2*NP)] = 1'b0;
      run(rand_tag());
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule